// File: doc/BRIEF.md
# Multi-Slot Core Address Decoder

This block sits between a single host register bus and a group of peripheral cores. The host issues a 17-bit address together with read and write strobes and write data. The block looks at the upper part of the address to decide which core is being addressed. It forwards the strobes to that core alone and hands the core only its local register index. Two cycles after a read, it returns the selected core's data to the host.

Most cores take up one slot of the core selector. One large core takes up four consecutive slots and sees a wider, 10-bit register index. That large core's storage is built from block memories, which add a clock of read latency. To match it, the ordinary cores' returned data passes through one extra register stage. Every read therefore completes with the same latency, whichever core it targets. Each core also receives its own copy of the system reset, in the polarity that core expects.

Top module: `core_slot_decoder`

## Requirements
- R1: The core selector is address bits [16:8] and the register selector is bits [7:0]. Ordinary core i owns selector value SMALL_BASE+i. It sees smallAddr equal to bits [7:0], and smallWdata equal to busWdata, whenever one of its strobes is high.
- R2: The large core owns the four selector values BIG_BASE to BIG_BASE+3, where BIG_BASE is a multiple of four. Its 10-bit index bigAddr is {(selector − BIG_BASE)[1:0], bits [7:0]}.
- R3: A write or read strobe reaches only the core that owns the current selector value. At most one core write strobe and at most one core read strobe are high in any cycle. A selector value that no core owns raises no core strobe.
- R4: Read data for a mapped address appears on busRdata exactly two clock cycles after the cycle in which busRd was high. This latency is the same for ordinary cores and for the large core.
- R5: With a new read issued every cycle, alternating between ordinary cores and the large core, each word on busRdata belongs to the address issued two cycles earlier.
- R6: A read at an unmapped selector value returns all zeros. A write at an unmapped selector value changes no core's stored contents. Selector values that differ from a mapped one only in the high bits are unmapped.
- R7: busRdata is all zeros in any cycle whose issue cycle, two clocks earlier, had busRd low.
- R8: Bit i of RST_LOW_MASK selects the reset polarity of ordinary core i, and bit NUM_SMALL selects that of the large core. A set bit gives an active-low reset that follows sysRstN. A clear bit gives an active-high reset, the inverse of sysRstN.
- R9: While sysRstN is low, the read-return pipeline is cleared and busRdata is zero. A read that is in flight when reset asserts returns nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sysRstN | input | 1 | System reset, active low, asynchronous |
| busAddr | input | 17 | Host address: core selector [16:8], register selector [7:0] |
| busWr | input | 1 | Host write strobe |
| busRd | input | 1 | Host read strobe |
| busWdata | input | DATA_W | Host write data |
| busRdata | output | DATA_W | Host read data, two cycles after the read |
| smallRst | output | NUM_SMALL | Per-core reset for the ordinary cores, polarity set by RST_LOW_MASK |
| smallWr | output | NUM_SMALL | Per-core write strobes for the ordinary cores |
| smallRd | output | NUM_SMALL | Per-core read strobes for the ordinary cores |
| smallAddr | output | 8 | Local register index shared by the ordinary cores |
| smallWdata | output | DATA_W | Write data shared by the ordinary cores |
| smallRdata | input | NUM_SMALL*DATA_W | Ordinary-core read data, core i in slice i, valid one cycle after its read strobe |
| bigRst | output | 1 | Reset for the large core |
| bigWr | output | 1 | Large-core write strobe |
| bigRd | output | 1 | Large-core read strobe |
| bigAddr | output | 10 | Large-core composite register index |
| bigWdata | output | DATA_W | Large-core write data |
| bigRdata | input | DATA_W | Large-core read data, valid two cycles after its read strobe |

## Verification
Two read returns are in flight in the same cycle when back-to-back reads alternate between an ordinary core and the large core. The ordinary core's word is waiting in the delay register while the large core's word leaves its memory pipeline, and the output must pick the right one. The bench provokes this with an alternating run of reads that also has gaps in it. Every returned word is compared with a value computed from the address issued two cycles earlier, or with zero when that issue cycle held no read. A full sweep of sixteen selector values plus aliasing high selectors, across all 256 register indices, first writes and then reads back every location. This checks strobe steering, index composition and the isolation of unmapped slots.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int ADDR_W    = 17;
  localparam int REG_W     = 8;
  localparam int SEL_W     = ADDR_W - REG_W;
  localparam int SPAN_LOG  = 2;
  localparam int BIG_REG_W = REG_W + SPAN_LOG;

  // read-return steering handed from control to datapath
  typedef struct packed {
    logic             rdS1;
    logic             smallHitS1;
    logic [SEL_W-1:0] smallIdxS1;
    logic             rdS2;
    logic             bigHitS2;
    logic             smallHitS2;
  } retCtrlT;
endpackage

// File: rtl/csd_ctrl.sv
module csd_ctrl
  import csd_pkg::*;
#(
  parameter int NUM_SMALL  = 4,
  parameter int SMALL_BASE = 0,
  parameter int BIG_BASE   = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWr,
  input  logic                  busRd,
  output logic [NUM_SMALL-1:0]  smallWr,
  output logic [NUM_SMALL-1:0]  smallRd,
  output logic                  bigWr,
  output logic                  bigRd,
  output logic [REG_W-1:0]      regIdx,
  output logic [BIG_REG_W-1:0]  bigIdx,
  output retCtrlT               retCtrl
);
  localparam logic [SEL_W-1:0] SMALL_LO  = SEL_W'(SMALL_BASE);
  localparam logic [SEL_W-1:0] SMALL_CNT = SEL_W'(NUM_SMALL);
  localparam logic [SEL_W-SPAN_LOG-1:0] BIG_GROUP = (SEL_W-SPAN_LOG)'(BIG_BASE >> SPAN_LOG);

  logic [SEL_W-1:0] coreSel;
  logic [SEL_W-1:0] smallOfs;
  logic             smallHit;
  logic             bigHit;

  assign coreSel  = busAddr[ADDR_W-1:REG_W];
  assign smallOfs = coreSel - SMALL_LO;
  assign smallHit = (coreSel >= SMALL_LO) && (smallOfs < SMALL_CNT);
  assign bigHit   = (coreSel[SEL_W-1:SPAN_LOG] == BIG_GROUP);

  assign regIdx = busAddr[REG_W-1:0];
  // base is a multiple of four, so the slot offset is the low selector bits
  assign bigIdx = {coreSel[SPAN_LOG-1:0], busAddr[REG_W-1:0]};

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SMALL; gi++) begin : g_strobe
      assign smallWr[gi] = busWr && smallHit && (smallOfs == SEL_W'(gi));
      assign smallRd[gi] = busRd && smallHit && (smallOfs == SEL_W'(gi));
    end
  endgenerate

  assign bigWr = busWr && bigHit;
  assign bigRd = busRd && bigHit;

  // return pipeline: stage 1 matches the core's own register, stage 2 the delay stage
  logic             rdS1, smallHitS1, bigHitS1;
  logic [SEL_W-1:0] smallIdxS1;
  logic             rdS2, smallHitS2, bigHitS2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdS1       <= 1'b0;
      smallHitS1 <= 1'b0;
      bigHitS1   <= 1'b0;
      smallIdxS1 <= '0;
      rdS2       <= 1'b0;
      smallHitS2 <= 1'b0;
      bigHitS2   <= 1'b0;
    end else begin
      rdS1       <= busRd;
      smallHitS1 <= busRd && smallHit;
      bigHitS1   <= busRd && bigHit;
      smallIdxS1 <= smallOfs;
      rdS2       <= rdS1;
      smallHitS2 <= smallHitS1;
      bigHitS2   <= bigHitS1;
    end
  end

  always_comb begin
    retCtrl.rdS1       = rdS1;
    retCtrl.smallHitS1 = smallHitS1;
    retCtrl.smallIdxS1 = smallIdxS1;
    retCtrl.rdS2       = rdS2;
    retCtrl.bigHitS2   = bigHitS2;
    retCtrl.smallHitS2 = smallHitS2;
  end
endmodule

// File: rtl/csd_datapath.sv
module csd_datapath
  import csd_pkg::*;
#(
  parameter int NUM_SMALL = 4,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  retCtrlT                     retCtrl,
  input  logic [NUM_SMALL*DATA_W-1:0] smallRdata,
  input  logic [DATA_W-1:0]           bigRdata,
  output logic [DATA_W-1:0]           busRdata
);
  logic [DATA_W-1:0] smallPick;
  logic [DATA_W-1:0] smallHold;

  // choose among ordinary cores first, then delay a single word
  always_comb begin
    smallPick = '0;
    for (int i = 0; i < NUM_SMALL; i++) begin
      if (retCtrl.rdS1 && retCtrl.smallHitS1 && retCtrl.smallIdxS1 == SEL_W'(i))
        smallPick = smallRdata[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) smallHold <= '0;
    else       smallHold <= smallPick;
  end

  always_comb begin
    busRdata = '0;
    if (retCtrl.rdS2) begin
      if (retCtrl.bigHitS2)        busRdata = bigRdata;
      else if (retCtrl.smallHitS2) busRdata = smallHold;
    end
  end
endmodule

// File: rtl/core_slot_decoder.sv
module core_slot_decoder
  import csd_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_SMALL  = 4,
  parameter int SMALL_BASE = 0,
  parameter int BIG_BASE   = 8,
  parameter logic [NUM_SMALL:0] RST_LOW_MASK = (NUM_SMALL+1)'(11)
) (
  input  logic                        clk,
  input  logic                        sysRstN,
  input  logic [16:0]                 busAddr,
  input  logic                        busWr,
  input  logic                        busRd,
  input  logic [DATA_W-1:0]           busWdata,
  output logic [DATA_W-1:0]           busRdata,
  output logic [NUM_SMALL-1:0]        smallRst,
  output logic [NUM_SMALL-1:0]        smallWr,
  output logic [NUM_SMALL-1:0]        smallRd,
  output logic [7:0]                  smallAddr,
  output logic [DATA_W-1:0]           smallWdata,
  input  logic [NUM_SMALL*DATA_W-1:0] smallRdata,
  output logic                        bigRst,
  output logic                        bigWr,
  output logic                        bigRd,
  output logic [9:0]                  bigAddr,
  output logic [DATA_W-1:0]           bigWdata,
  input  logic [DATA_W-1:0]           bigRdata
);
  retCtrlT retCtrl;

  csd_ctrl #(
    .NUM_SMALL(NUM_SMALL), .SMALL_BASE(SMALL_BASE), .BIG_BASE(BIG_BASE)
  ) ctrl_i (
    .clk(clk), .rstN(sysRstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .smallWr(smallWr), .smallRd(smallRd), .bigWr(bigWr), .bigRd(bigRd),
    .regIdx(smallAddr), .bigIdx(bigAddr), .retCtrl(retCtrl)
  );

  csd_datapath #(
    .NUM_SMALL(NUM_SMALL), .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk), .rstN(sysRstN), .retCtrl(retCtrl),
    .smallRdata(smallRdata), .bigRdata(bigRdata), .busRdata(busRdata)
  );

  assign smallWdata = busWdata;
  assign bigWdata   = busWdata;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SMALL; gi++) begin : g_rst
      if (RST_LOW_MASK[gi]) begin : g_low
        assign smallRst[gi] = sysRstN;
      end else begin : g_high
        assign smallRst[gi] = ~sysRstN;
      end
    end
    if (RST_LOW_MASK[NUM_SMALL]) begin : g_big_low
      assign bigRst = sysRstN;
    end else begin : g_big_high
      assign bigRst = ~sysRstN;
    end
  endgenerate
endmodule

// File: rtl/csd_chk.sv
module csd_chk #(
  parameter int DATA_W    = 32,
  parameter int NUM_SMALL = 4,
  parameter int BIG_BASE  = 8
) (
  input logic                 clk,
  input logic                 sysRstN,
  input logic [16:0]          busAddr,
  input logic                 busWr,
  input logic                 busRd,
  input logic [DATA_W-1:0]    busRdata,
  input logic [NUM_SMALL-1:0] smallWr,
  input logic [NUM_SMALL-1:0] smallRd,
  input logic [7:0]           smallAddr,
  input logic                 bigWr,
  input logic                 bigRd,
  input logic [9:0]           bigAddr
);
  assert_one_writer_R3: assert property (@(posedge clk) disable iff (!sysRstN)
    $onehot0({smallWr, bigWr}));

  assert_one_reader_R3: assert property (@(posedge clk) disable iff (!sysRstN)
    $onehot0({smallRd, bigRd}));

  assert_no_stray_strobe_R3: assert property (@(posedge clk) disable iff (!sysRstN)
    (!busWr && !busRd) |-> ({smallWr, smallRd, bigWr, bigRd} == '0));

  assert_local_index_R1: assert property (@(posedge clk) disable iff (!sysRstN)
    (|{smallWr, smallRd}) |-> (smallAddr == busAddr[7:0]));

  assert_big_window_R2: assert property (@(posedge clk) disable iff (!sysRstN)
    (bigWr || bigRd) |-> (busAddr[16:10] == 7'(BIG_BASE >> 2) && bigAddr == busAddr[9:0]));

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!sysRstN)
    !$past(busRd, 2) |-> (busRdata == '0));
endmodule

bind core_slot_decoder csd_chk #(
  .DATA_W(DATA_W), .NUM_SMALL(NUM_SMALL), .BIG_BASE(BIG_BASE)
) chk_i (
  .clk(clk), .sysRstN(sysRstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .busRdata(busRdata), .smallWr(smallWr), .smallRd(smallRd), .smallAddr(smallAddr),
  .bigWr(bigWr), .bigRd(bigRd), .bigAddr(bigAddr)
);

// File: tb/core_slot_decoder_tb_top.sv
`timescale 1ns/1ps
module core_slot_decoder_tb_top;
  localparam int DW = 32;
  localparam int NS = 4;
  localparam logic [NS:0] MASK = 5'b01011;

  logic clk = 1'b0;
  logic sysRstN = 1'b0;
  logic [16:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic [NS-1:0] smallRst, smallWr, smallRd;
  logic [7:0] smallAddr;
  logic [DW-1:0] smallWdata;
  logic [NS*DW-1:0] smallRdata;
  logic bigRst, bigWr, bigRd;
  logic [9:0] bigAddr;
  logic [DW-1:0] bigWdata, bigRdata;

  always #2.5 clk = ~clk;

  core_slot_decoder #(.DATA_W(DW), .NUM_SMALL(NS), .SMALL_BASE(0), .BIG_BASE(8),
                      .RST_LOW_MASK(MASK)) dut_i (
    .clk(clk), .sysRstN(sysRstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .smallRst(smallRst), .smallWr(smallWr),
    .smallRd(smallRd), .smallAddr(smallAddr), .smallWdata(smallWdata),
    .smallRdata(smallRdata), .bigRst(bigRst), .bigWr(bigWr), .bigRd(bigRd),
    .bigAddr(bigAddr), .bigWdata(bigWdata), .bigRdata(bigRdata)
  );

  // core stubs: ordinary cores answer one cycle after the strobe, the large core two
  logic [DW-1:0] sMem [NS][256];
  logic [DW-1:0] sOut [NS];
  logic [DW-1:0] bMem [1024];
  logic [DW-1:0] bPipe1, bPipe2;

  initial begin
    for (int c = 0; c < NS; c++) begin
      sOut[c] = '0;
      for (int r = 0; r < 256; r++) sMem[c][r] = '0;
    end
    for (int r = 0; r < 1024; r++) bMem[r] = '0;
    bPipe1 = '0;
    bPipe2 = '0;
  end

  always @(posedge clk) begin
    for (int c = 0; c < NS; c++) begin
      if (smallWr[c]) sMem[c][smallAddr] <= smallWdata;
      if (smallRd[c]) sOut[c] <= sMem[c][smallAddr];
    end
    if (bigWr) bMem[bigAddr] <= bigWdata;
    bPipe1 <= bMem[bigAddr];
    bPipe2 <= bPipe1;
  end

  always_comb for (int c = 0; c < NS; c++) smallRdata[c*DW +: DW] = sOut[c];
  assign bigRdata = bPipe2;

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] hashOf(input logic [16:0] a);
    return (32'h9E37_79B9 * ({15'd0, a} + 32'd1)) ^ {15'd0, a};
  endfunction

  function automatic logic [8:0] selOf(input int k);
    case (k)
      16: return 9'd264;
      17: return 9'd265;
      18: return 9'd260;
      19: return 9'd511;
      default: return 9'(k);
    endcase
  endfunction

  function automatic bit isSmall(input logic [8:0] s); return s < 9'd4; endfunction
  function automatic bit isBig(input logic [8:0] s);   return s >= 9'd8 && s <= 9'd11; endfunction

  function automatic logic [DW-1:0] expRead(input logic [16:0] a);
    if (isSmall(a[16:8]) || isBig(a[16:8])) return hashOf(a);
    return '0;
  endfunction

  function automatic logic [9:0] strobesExp(input logic [8:0] s, input bit wr, input bit rd);
    logic [3:0] sv;
    sv = isSmall(s) ? 4'(1 << s[1:0]) : 4'd0;
    return {wr ? sv : 4'd0, rd ? sv : 4'd0, wr && isBig(s), rd && isBig(s)};
  endfunction

  task automatic drive(input logic [16:0] a, input bit wr, input bit rd, input logic [DW-1:0] d);
    busAddr = a; busWr = wr; busRd = rd; busWdata = d;
  endtask

  logic [DW-1:0] expQ1, expQ2;
  bit vQ1, vQ2;
  string tagQ1, tagQ2;

  // sample what was issued two negedges ago, then shift in the new read
  task automatic pipeStep(input bit rd, input logic [16:0] a);
    if (vQ2) check(busRdata == expQ2, tagQ2, busRdata, expQ2);
    expQ2 = expQ1; vQ2 = vQ1; tagQ2 = tagQ1;
    expQ1 = rd ? expRead(a) : '0; vQ1 = 1'b1;
    tagQ1 = !rd ? "R7 gap" : (expRead(a) == '0 ? "R6 unmapped read" : "R5 return data");
    drive(a, 1'b0, rd, '0);
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [16:0] a;
    logic [9:0] sExp;
    vQ1 = 0; vQ2 = 0; expQ1 = '0; expQ2 = '0; tagQ1 = ""; tagQ2 = "";

    // reset state
    repeat (3) @(negedge clk);
    check(busRdata == '0, "R9 rdata in reset", busRdata, '0);
    check({bigRst, smallRst} == ~MASK, "R8 reset levels asserted", 32'({bigRst, smallRst}), 32'(~MASK));
    sysRstN = 1'b1;
    @(negedge clk);
    check({bigRst, smallRst} == MASK, "R8 reset levels released", 32'({bigRst, smallRst}), 32'(MASK));

    // write sweep, unmapped slots written after their mapped neighbours
    for (int k = 0; k < 20; k++) begin
      for (int r = 0; r < 256; r++) begin
        @(negedge clk);
        a = {selOf(k), 8'(r)};
        drive(a, 1'b1, 1'b0, (isSmall(a[16:8]) || isBig(a[16:8])) ? hashOf(a) : ~hashOf(a));
        #1;
        sExp = strobesExp(a[16:8], 1'b1, 1'b0);
        check({smallWr, smallRd, bigWr, bigRd} == sExp, "R3 write steering",
              32'({smallWr, smallRd, bigWr, bigRd}), 32'(sExp));
        if (isSmall(a[16:8]))
          check(smallAddr == a[7:0] && smallWdata == busWdata, "R1 local index",
                32'(smallAddr), 32'(a[7:0]));
        if (isBig(a[16:8]))
          check(bigAddr == {a[9:8], a[7:0]}, "R2 composite index", 32'(bigAddr), 32'(a[9:0]));
      end
    end
    @(negedge clk); drive('0, 1'b0, 1'b0, '0);

    // back-to-back read sweep, two-cycle return
    for (int k = 0; k < 20; k++) begin
      for (int r = 0; r < 256; r++) begin
        @(negedge clk);
        a = {selOf(k), 8'(r)};
        pipeStep(1'b1, a);
        #1;
        sExp = strobesExp(a[16:8], 1'b0, 1'b1);
        check({smallWr, smallRd, bigWr, bigRd} == sExp, "R3 read steering",
              32'({smallWr, smallRd, bigWr, bigRd}), 32'(sExp));
      end
    end

    // alternate ordinary and large core every cycle, with read gaps (R4 R5 R7)
    for (int k = 0; k < 96; k++) begin
      @(negedge clk);
      a = (k % 2 == 0) ? {9'(k % 4), 8'(k)} : {9'(8 + (k % 4)), 8'(255 - k)};
      pipeStep((k % 5) != 4, a);
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      pipeStep(1'b0, {9'd8, 8'd0});
    end

    // read in flight when reset asserts returns nothing
    @(negedge clk); drive({9'd9, 8'd3}, 1'b0, 1'b1, '0);
    @(negedge clk); drive('0, 1'b0, 1'b0, '0); sysRstN = 1'b0;
    @(negedge clk);
    check(busRdata == '0, "R9 flushed read", busRdata, '0);
    sysRstN = 1'b1;
    @(negedge clk);
    check(busRdata == '0, "R9 after release", busRdata, '0);

    // single isolated read: R4 latency exactly two
    @(negedge clk); drive({9'd2, 8'd77}, 1'b0, 1'b1, '0);
    @(negedge clk); drive('0, 1'b0, 1'b0, '0);
    check(busRdata == '0, "R4 not early", busRdata, '0);
    @(negedge clk);
    check(busRdata == hashOf({9'd2, 8'd77}), "R4 latency two", busRdata, hashOf({9'd2, 8'd77}));
    @(negedge clk);
    check(busRdata == '0, "R7 after return", busRdata, '0);

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule